// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer with Trigger Output

This block is a general-purpose up/down timer for a larger chip. A programmable prescaler divides the system clock into count ticks. A counter steps once per tick and wraps at an auto-reload limit. Each wrap raises a one-cycle update event, so the event rate is the clock divided by (prescaler+1) and then by (auto-reload+1).

The prescaler and the auto-reload limit both sit behind shadow registers. The prescaler shadow changes only at an update event. The auto-reload shadow can be bypassed, so a newly written limit acts at once. When the shadow is in use, the new limit waits for the next update. Software can force an update through the write port. A forced update reloads both shadows, clears the prescaler and restarts the counter.

A single trigger output feeds other timers. It is picked by a 3-bit mode from eight sources: the forced-update strobe, the enable level, the update pulse, an external compare pulse, or one of four external compare reference levels.

Top module: `tmr_trig_top`

## Requirements
- R1: After reset, cnt_o is 0, upd_o is 0 and trg_o is 0, and all written fields are 0 (disabled, counting up, shadow bypassed, mode 0).
- R2: With the counter enabled, prescaler P and limit A, consecutive upd_o pulses are exactly (P+1)*(A+1) clock cycles apart. When that product exceeds 1, upd_o is high for only one cycle.
- R3: Counting up (direction bit 0), the counter wraps to 0 on the tick after it reaches the limit. Counting down (direction bit 1), it reloads to the limit on the tick after it reaches 0. Each wrap raises upd_o.
- R4: With the auto-reload shadow enabled (control bit 1 = 1), a limit written mid-period takes effect only after the next update. With it disabled, the new limit governs the running period at once.
- R5: Writing 1 to bit 0 of address 5 forces an update. upd_o is high in the following cycle, even when the counter is disabled. Both shadows load, the prescaler count clears, and the counter becomes 0 (up) or the newly written limit (down).
- R6: With enable (control bit 0) at 0, the counter holds its value and no update occurs. A write to address 3 loads the counter, whether it is enabled or not.
- R7: The trigger mode (address 4, bits 2:0) selects trg_o: 0 = forced-update strobe (one cycle, together with its upd_o pulse), 1 = enable level, 2 = upd_o, 3 = cmp_pulse_i, 4..7 = cmp_ref_i[0..3].
- R8: Write map: address 0 control {bit2 direction, bit1 shadow enable, bit0 enable}; address 1 prescaler; address 2 limit; address 3 counter; address 4 trigger mode; address 5 event strobe. A write takes effect at the clock edge that samples wr_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| cmp_pulse_i | input | 1 | External compare pulse for mode 3 |
| cmp_ref_i | input | 4 | External compare references for modes 4..7 |
| cnt_o | output | 16 | Current counter value |
| upd_o | output | 1 | Update event pulse |
| trg_o | output | 1 | Selected trigger output |

## Verification
The hardest case to reach is a limit change that lands in the middle of a running period. The outcome depends on whether the shadow is in use, and it shows only in the length of that period and the next one. The stimulus forces an update to align the counter at a known cycle. It then writes the new limit exactly one cycle later and measures the cycles to each of the next two update pulses. The prescaler clear is reached the same way: each table vector forces an update while the counter is already running under different settings.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W  = 3;
    localparam int MODE_W  = 3;
    localparam int NUM_REF = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_PSC  = 3'd1,
        A_ARR  = 3'd2,
        A_CNT  = 3'd3,
        A_MODE = 3'd4,
        A_EVT  = 3'd5
    } reg_addr_e;

    typedef enum logic [MODE_W-1:0] {
        M_RESET  = 3'd0,
        M_ENABLE = 3'd1,
        M_UPDATE = 3'd2,
        M_CPULSE = 3'd3
    } trg_mode_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PSC_W  = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              en,
    output logic              arpe,
    output logic              dir,
    output logic [MODE_W-1:0] mode,
    output logic [PSC_W-1:0]  psc_pre,
    output logic [CNT_W-1:0]  arr_pre,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_wdata,
    output logic              ug
);
    typedef struct packed {
        logic              en;
        logic              arpe;
        logic              dir;
        logic [MODE_W-1:0] mode;
        logic [PSC_W-1:0]  psc;
        logic [CNT_W-1:0]  arr;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        cnt_wr    = 1'b0;
        ug        = 1'b0;
        cnt_wdata = wr_data[CNT_W-1:0];
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                A_CTRL: begin
                    r_d.en   = wr_data[0];
                    r_d.arpe = wr_data[1];
                    r_d.dir  = wr_data[2];
                end
                A_PSC:  r_d.psc  = wr_data[PSC_W-1:0];
                A_ARR:  r_d.arr  = wr_data[CNT_W-1:0];
                A_CNT:  cnt_wr   = 1'b1;
                A_MODE: r_d.mode = wr_data[MODE_W-1:0];
                A_EVT:  ug       = wr_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign en      = r_q.en;
    assign arpe    = r_q.arpe;
    assign dir     = r_q.dir;
    assign mode    = r_q.mode;
    assign psc_pre = r_q.psc;
    assign arr_pre = r_q.arr;

    // R8: a write to an unrelated address leaves the limit untouched
    a_r8_arr_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != A_ARR) |=> $stable(arr_pre));
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int PSC_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             arpe,
    input  logic             dir,
    input  logic [PSC_W-1:0] psc_pre,
    input  logic [CNT_W-1:0] arr_pre,
    input  logic             ug,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             upd,
    output logic             ug_pulse
);
    typedef struct packed {
        logic [PSC_W-1:0] pc;
        logic [PSC_W-1:0] psc_sh;
        logic [CNT_W-1:0] arr_sh;
        logic [CNT_W-1:0] cnt;
        logic             upd;
        logic             ugp;
    } core_t;

    core_t c_d, c_q;
    logic [CNT_W-1:0] arr_act;
    logic             tick;
    logic             wrap;

    always_comb begin
        c_d     = c_q;
        c_d.upd = 1'b0;
        c_d.ugp = 1'b0;
        arr_act = arpe ? c_q.arr_sh : arr_pre;
        tick    = en && (c_q.pc >= c_q.psc_sh);
        wrap    = dir ? (c_q.cnt == '0) : (c_q.cnt >= arr_act);

        if (ug) begin
            c_d.pc     = '0;
            c_d.psc_sh = psc_pre;
            c_d.arr_sh = arr_pre;
            c_d.cnt    = dir ? arr_pre : '0;
            c_d.upd    = 1'b1;
            c_d.ugp    = 1'b1;
        end else begin
            if (en) c_d.pc = tick ? '0 : c_q.pc + 1'b1;
            if (cnt_wr) begin
                c_d.cnt = cnt_wdata;
            end else if (tick) begin
                if (wrap) begin
                    c_d.cnt    = dir ? arr_pre : '0;
                    c_d.upd    = 1'b1;
                    c_d.psc_sh = psc_pre;
                    c_d.arr_sh = arr_pre;
                end else begin
                    c_d.cnt = dir ? c_q.cnt - 1'b1 : c_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt      = c_q.cnt;
    assign upd      = c_q.upd;
    assign ug_pulse = c_q.ugp;

    // R6: disabled counter holds without a direct write or forced update
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !ug && !cnt_wr) |=> $stable(cnt));
    // R2: between prescaler ticks the counter does not move
    a_r2_prescale_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick && !ug && !cnt_wr) |=> ($stable(cnt) && !upd));
    // R5: forced update yields an update pulse and a cleared prescaler
    a_r5_force: assert property (@(posedge clk) disable iff (!rst_n)
        ug |=> (upd && c_q.pc == '0));
    // R5: forced update counting up restarts at zero
    a_r5_up_start: assert property (@(posedge clk) disable iff (!rst_n)
        (ug && !dir) |=> (cnt == '0));
    // R4: shadowed limit changes only at an update event
    a_r4_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        !c_d.upd |=> $stable(c_q.arr_sh));
endmodule

// File: rtl/tmr_trgsel.sv
module tmr_trgsel
    import tmr_pkg::*;
(
    input  logic               mode_valid,
    input  logic [MODE_W-1:0]  mode,
    input  logic               ug_pulse,
    input  logic               en,
    input  logic               upd,
    input  logic               cmp_pulse,
    input  logic [NUM_REF-1:0] cmp_ref,
    output logic               trg
);
    always_comb begin
        trg = 1'b0;
        if (mode_valid) begin
            case (trg_mode_e'(mode))
                M_RESET:  trg = ug_pulse;
                M_ENABLE: trg = en;
                M_UPDATE: trg = upd;
                M_CPULSE: trg = cmp_pulse;
                default: begin
                    for (int i = 0; i < NUM_REF; i++) begin
                        if (int'(mode) == int'(M_CPULSE) + 1 + i) trg = cmp_ref[i];
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/tmr_trig_top.sv
module tmr_trig_top
    import tmr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PSC_W  = 16,
    parameter int CNT_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               cmp_pulse_i,
    input  logic [NUM_REF-1:0] cmp_ref_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               upd_o,
    output logic               trg_o
);
    logic              en, arpe, dir, cnt_wr, ug, ug_pulse;
    logic [MODE_W-1:0] mode;
    logic [PSC_W-1:0]  psc_pre;
    logic [CNT_W-1:0]  arr_pre, cnt_wdata;

    tmr_regs #(.DATA_W(DATA_W), .PSC_W(PSC_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .en(en), .arpe(arpe), .dir(dir), .mode(mode),
        .psc_pre(psc_pre), .arr_pre(arr_pre), .cnt_wr(cnt_wr),
        .cnt_wdata(cnt_wdata), .ug(ug)
    );

    tmr_core #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(en), .arpe(arpe), .dir(dir),
        .psc_pre(psc_pre), .arr_pre(arr_pre), .ug(ug), .cnt_wr(cnt_wr),
        .cnt_wdata(cnt_wdata), .cnt(cnt_o), .upd(upd_o), .ug_pulse(ug_pulse)
    );

    tmr_trgsel u_sel (
        .mode_valid(1'b1), .mode(mode), .ug_pulse(ug_pulse), .en(en),
        .upd(upd_o), .cmp_pulse(cmp_pulse_i), .cmp_ref(cmp_ref_i), .trg(trg_o)
    );

    // R7: update mode mirrors the core's update pulse
    a_r7_update_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2) |-> (trg_o == upd_o));
    // R7: reset mode never fires without an update pulse
    a_r7_reset_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && trg_o) |-> upd_o);
    // R1: outputs are quiet right after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (cnt_o == '0 || !rst_n));
endmodule

// File: tb/tmr_trig_top_bench.sv
module tmr_trig_top_bench;
    localparam int CLK_P = 10;
    localparam int NV    = 6;
    localparam int V_PSC [NV] = '{0, 2, 1, 3, 0, 4};
    localparam int V_ARR [NV] = '{3, 4, 5, 0, 0, 2};
    localparam int V_DIR [NV] = '{0, 0, 1, 0, 1, 1};
    localparam int V_PER [NV] = '{4, 15, 12, 4, 1, 15};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        cmp_pulse_i = 1'b0;
    logic [3:0]  cmp_ref_i = '0;
    logic [15:0] cnt_o;
    logic        upd_o, trg_o;
    int          total = 0;
    int          fails = 0;

    always #(CLK_P/2) clk = ~clk;

    tmr_trig_top u_tmr_trig_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmp_pulse_i(cmp_pulse_i), .cmp_ref_i(cmp_ref_i),
        .cnt_o(cnt_o), .upd_o(upd_o), .trg_o(trg_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        wr_en   = 1'b1;
        wr_addr = 3'(addr);
        wr_data = 16'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_upd(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!upd_o && n < 2000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int n;
        int ups;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cnt", cnt_o, 0);
        check("R1 upd", upd_o, 0);
        check("R1 trg", trg_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle cnt", cnt_o, 0);

        // R2/R3/R5/R8 table walk
        for (int v = 0; v < NV; v++) begin
            wr(1, V_PSC[v]);
            wr(2, V_ARR[v]);
            wr(0, 1 | (V_DIR[v] << 2));
            repeat (3) @(negedge clk);
            wr(5, 1);
            check($sformatf("R5 ug pulse v%0d", v), upd_o, 1);
            check($sformatf("R3 start v%0d", v), cnt_o, V_DIR[v] ? V_ARR[v] : 0);
            wait_upd(n);
            check($sformatf("R2 period1 v%0d", v), n, V_PER[v]);
            wait_upd(n);
            check($sformatf("R2 period2 v%0d", v), n, V_PER[v]);
            if (V_PER[v] > 1) begin
                @(negedge clk);
                check($sformatf("R2 single v%0d", v), upd_o, 0);
            end
        end

        // R3 up sequence with prescaler 0, limit 2
        wr(1, 0); wr(2, 2); wr(0, 1);
        wr(5, 1);
        @(negedge clk); check("R3 up 1", cnt_o, 1);
        @(negedge clk); check("R3 up 2", cnt_o, 2);
        @(negedge clk); check("R3 up wrap", cnt_o, 0);
        check("R3 up upd", upd_o, 1);
        // R3 down sequence
        wr(0, 5);
        wr(5, 1);
        check("R3 down start", cnt_o, 2);
        @(negedge clk); check("R3 down 1", cnt_o, 1);
        @(negedge clk); check("R3 down 0", cnt_o, 0);
        @(negedge clk); check("R3 down reload", cnt_o, 2);
        check("R3 down upd", upd_o, 1);

        // R4 shadow enabled: mid-period write waits
        wr(1, 0); wr(2, 9); wr(0, 3);
        wr(5, 1);
        wr(2, 4);
        wait_upd(n);
        check("R4 shadow old period", n + 1, 10);
        wait_upd(n);
        check("R4 shadow new period", n, 5);
        // R4 shadow bypassed: immediate
        wr(2, 9); wr(0, 1);
        wr(5, 1);
        wr(2, 4);
        wait_upd(n);
        check("R4 bypass period", n + 1, 5);

        // R6 disabled hold and counter write
        wr(0, 0);
        wr(3, 7);
        check("R6 cnt write", cnt_o, 7);
        ups = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (upd_o) ups++;
        end
        check("R6 hold", cnt_o, 7);
        check("R6 no upd", ups, 0);

        // R5 forced update while disabled loads shadows
        wr(1, 1); wr(2, 2); wr(0, 2);
        wr(5, 1);
        check("R5 disabled ug", upd_o, 1);
        wr(0, 3);
        wait_upd(n);
        check("R5 shadows loaded", n, 6);

        // R7 trigger modes
        wr(4, 1);
        check("R7 enable on", trg_o, 1);
        wr(0, 0);
        check("R7 enable off", trg_o, 0);
        cmp_ref_i = 4'b0100;
        for (int m = 4; m < 8; m++) begin
            wr(4, m);
            check($sformatf("R7 ref mode %0d", m), trg_o, (m == 6) ? 1 : 0);
        end
        cmp_ref_i = 4'b1011;
        wr(4, 7);
        check("R7 ref4 hi", trg_o, 1);
        wr(4, 3);
        cmp_pulse_i = 1'b1; @(negedge clk);
        check("R7 cpulse hi", trg_o, 1);
        cmp_pulse_i = 1'b0; @(negedge clk);
        check("R7 cpulse lo", trg_o, 0);
        wr(1, 0); wr(2, 1); wr(0, 1);
        wr(4, 2);
        ups = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (trg_o != upd_o) ups++;
        end
        check("R7 update mode", ups, 0);
        wr(4, 0);
        ups = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (trg_o) ups++;
        end
        check("R7 reset quiet", ups, 0);
        wr(5, 1);
        check("R7 reset strobe", trg_o, 1);
        @(negedge clk);
        check("R7 reset strobe end", trg_o, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule